// File: doc/BRIEF.md
# I2C Target Address and Acknowledge Engine

This block is the receive side of an I2C target. It watches the SCL and SDA lines through synchronisers clocked by the system clock. It finds start, repeated-start and stop conditions, and shifts in the first byte after each start. That byte holds a 7-bit address, most significant bit first, followed by a direction bit. The address is compared with a programmed local address. It is also tested against the reserved extension-code pattern.

When either comparison hits, the block pulses an interrupt for one cycle and latches the direction. On the ninth clock it pulls SDA low, but only if the acknowledge-enable input is high. In write transfers (direction 0) each later byte appears on a byte-valid strobe and is acknowledged under the same enable. In read transfers (direction 1) the block releases SDA and samples the controller's acknowledge on each ninth clock. A NACK there ends the transfer. An address that matches nothing makes the block ignore the bus until the next start or stop. SDA is open-drain and is modelled as an active-high pull-down enable.

Top module: `i2c_tgt_addr_ack`

## Requirements
- R1: After reset, `sda_oe`, `irq`, `rx_valid`, `dir_flag` and `addressed` are all 0.
- R2: The address byte is taken MSB first: seven address bits, then the direction bit as the eighth bit. When the address equals `own_addr`, `irq` goes high for exactly one system clock cycle.
- R3: An address whose top five bits are 11110 (binary) raises `irq` whatever the value of `own_addr`, and the two low address bits are ignored.
- R4: After an address that neither matches nor is an extension code, there is no `irq`, `sda_oe` stays 0, and later bytes give no `rx_valid` until the next start or stop.
- R5: On a hit, `dir_flag` takes the value of the eighth bit. 0 means the controller writes (the target receives) and 1 means the controller reads. `addressed` is 1 after the ninth clock of a hit.
- R6: On the ninth SCL clock of an address or write-data byte, `sda_oe` is 1 while SCL is high if `ack_en` was 1 when the eighth bit arrived, and 0 otherwise.
- R7: In write mode each data byte appears on `rx_data` with a single-cycle `rx_valid` pulse after its eighth bit. `rx_valid` never rises while `dir_flag` is 1.
- R8: In read mode the block never pulls SDA low. It samples SDA on the ninth clock: a low level keeps `addressed` at 1, and a high level (NACK) clears `addressed` and ignores the bus until the next start.
- R9: A repeated start returns the block to the address phase, where the new address is judged afresh. A stop clears `addressed`.
- R10: `sda_oe` is only ever asserted while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr | input | 7 | Programmed local address |
| ack_en | input | 1 | Enables automatic acknowledge |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | One-cycle pulse on an address or extension-code hit |
| dir_flag | output | 1 | Latched direction: 1 = target transmits |
| addressed | output | 1 | Block is selected in a data phase |
| rx_data | output | 8 | Last received write-data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
A table of address bytes drives the comparator with several kinds of address:
- an exact match, in both directions;
- addresses that differ from the local one only in the lowest bit, or only in the highest bit;
- two extension codes with different low bits;
- an address of 11111xx, which must not count as an extension code;
- a match with acknowledge disabled.

Together these separate a correct compare from one that drops an end bit, mis-masks the extension pattern, or ignores the enable. Directed sequences then cover:
- write data with acknowledge on and then off;
- data that follows a non-matching address;
- read transfers ended by an ACK and then by a NACK;
- repeated starts that switch between a miss and a hit.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    // reserved 11110xx pattern in the upper address bits
    localparam logic [4:0] EXT_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_RX,
        PH_TX
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              done;        // eighth bit sampled
        logic              ninth_rise;  // rising edge of the ack clock
        logic              ack_fall;    // falling edge opening the ack slot
        logic              slot_end;    // falling edge closing the ack slot
        logic [BYTE_W-1:0] data;
    } slot_t;

    function automatic logic is_ext_code(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: 5] == EXT_PREFIX;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[i] <= 1'b1;
                    sda_ff[i] <= 1'b1;
                end else if (i == 0) begin
                    scl_ff[i] <= scl_i;
                    sda_ff[i] <= sda_i;
                end else begin
                    scl_ff[i] <= scl_ff[(i == 0) ? 0 : i-1];
                    sda_ff[i] <= sda_ff[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ff[STAGES-1];
            sda_q <= sda_ff[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_ff[STAGES-1];
        ev.sda      = sda_ff[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end

endmodule

// File: rtl/i2c_tgt_shifter.sv
module i2c_tgt_shifter
    import i2c_tgt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  scl_rise,
    input  logic  scl_fall,
    input  logic  sda,
    output slot_t slot
);

    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(BYTE_W + 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else begin
            if (scl_rise) begin
                if (cnt < ACK_BIT) begin
                    shreg <= {shreg[BYTE_W-3:0], sda};
                end
                if (cnt <= ACK_BIT) begin
                    cnt <= cnt + 1'b1;
                end
            end else if (scl_fall && cnt == SLOT_END) begin
                cnt <= '0;
            end
        end
    end

    always_comb begin
        slot.done       = scl_rise && cnt == LAST_BIT;
        slot.ninth_rise = scl_rise && cnt == ACK_BIT;
        slot.ack_fall   = scl_fall && cnt == ACK_BIT;
        slot.slot_end   = scl_fall && cnt == SLOT_END;
        slot.data       = {shreg, sda};
    end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              sda,
    input  slot_t             slot,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    output phase_e            phase,
    output logic              sda_oe,
    output logic              irq,
    output logic              dir_flag,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    logic ack_pend;
    logic tx_nack;
    logic addr_hit;

    always_comb begin
        addr_hit = (slot.data[BYTE_W-1:1] == own_addr)
                 || is_ext_code(slot.data[BYTE_W-1:1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            sda_oe   <= 1'b0;
            irq      <= 1'b0;
            dir_flag <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            ack_pend <= 1'b0;
            tx_nack  <= 1'b0;
        end else begin
            irq      <= 1'b0;
            rx_valid <= 1'b0;
            if (start) begin
                phase    <= PH_ADDR;
                sda_oe   <= 1'b0;
                ack_pend <= 1'b0;
                tx_nack  <= 1'b0;
            end else if (stop) begin
                phase    <= PH_IDLE;
                sda_oe   <= 1'b0;
                ack_pend <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (slot.done) begin
                    case (phase)
                        PH_ADDR: begin
                            if (addr_hit) begin
                                irq      <= 1'b1;
                                dir_flag <= slot.data[0];
                                ack_pend <= ack_en;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                        PH_RX: begin
                            rx_data  <= slot.data;
                            rx_valid <= 1'b1;
                            ack_pend <= ack_en;
                        end
                        default: ack_pend <= 1'b0;
                    endcase
                end
                if (slot.ninth_rise && phase == PH_TX) begin
                    tx_nack <= sda;
                end
                if (slot.ack_fall) begin
                    sda_oe <= ack_pend;
                end
                if (slot.slot_end) begin
                    sda_oe   <= 1'b0;
                    ack_pend <= 1'b0;
                    if (phase == PH_ADDR) begin
                        phase <= dir_flag ? PH_TX : PH_RX;
                    end else if (phase == PH_TX && tx_nack) begin
                        phase <= PH_IDLE;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_addr_ack.sv
module i2c_tgt_addr_ack
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    output logic              sda_oe,
    output logic              irq,
    output logic              dir_flag,
    output logic              addressed,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);

    bus_ev_t ev;
    slot_t   slot;
    phase_e  phase;
    logic    scl_s;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (ev.start | ev.stop),
        .scl_rise (ev.scl_rise),
        .scl_fall (ev.scl_fall),
        .sda      (ev.sda),
        .slot     (slot)
    );

    i2c_tgt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (ev.start),
        .stop     (ev.stop),
        .sda      (ev.sda),
        .slot     (slot),
        .own_addr (own_addr),
        .ack_en   (ack_en),
        .phase    (phase),
        .sda_oe   (sda_oe),
        .irq      (irq),
        .dir_flag (dir_flag),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    assign scl_s     = ev.scl;
    assign addressed = (phase == PH_RX) || (phase == PH_TX);

endmodule

// File: rtl/i2c_tgt_addr_ack_chk.sv
module i2c_tgt_addr_ack_chk
    import i2c_tgt_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   scl_s,
    input logic   sda_oe,
    input logic   irq,
    input logic   rx_valid,
    input logic   dir_flag,
    input phase_e phase
);

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    // R2
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    rx_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> !dir_flag);

    // R4
    oe_engaged_chk: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> phase != PH_IDLE);

    // R8
    tx_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TX) |-> !sda_oe);

endmodule

bind i2c_tgt_addr_ack i2c_tgt_addr_ack_chk u_chk (.*);

// File: tb/i2c_tgt_addr_ack_test.sv
module i2c_tgt_addr_ack_test;
    import i2c_tgt_pkg::*;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic [6:0] own_addr = 7'h52;
    logic       ack_en = 1'b1;
    logic       sda_oe, irq, dir_flag, addressed, rx_valid;
    logic [7:0] rx_data;
    logic       bus_sda;

    int n_chk = 0, n_bad = 0;
    int irq_cnt = 0, rxv_cnt = 0, oe_bad = 0, oe_cnt = 0;
    int cyc = 0;

    assign bus_sda = sda_drv & ~sda_oe;

    always #5 clk = ~clk;

    i2c_tgt_addr_ack uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda),
        .own_addr(own_addr), .ack_en(ack_en), .sda_oe(sda_oe), .irq(irq),
        .dir_flag(dir_flag), .addressed(addressed), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
        if (rx_valid) rxv_cnt <= rxv_cnt + 1;
        if (sda_oe) oe_cnt <= oe_cnt + 1;
        if (sda_oe && scl && uut.u_sync.ev.scl == 1'b0) oe_bad <= oe_bad;
    end

    // R10 observed at the pins: pull-down must never begin while SCL is high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (sda_oe && !oe_prev && scl) oe_bad = oe_bad + 1;
        oe_prev = sda_oe;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_drv = 1'b1; wt(H);
        scl = 1'b1; wt(H);
        sda_drv = 1'b0; wt(H);
        scl = 1'b0; wt(H);
    endtask

    task automatic do_stop();
        sda_drv = 1'b0; wt(H);
        scl = 1'b1; wt(H);
        sda_drv = 1'b1; wt(H);
    endtask

    // eight bits MSB first, then ninth clock with bench driving 'ninth'
    task automatic send_byte(input logic [7:0] b, input logic ninth, output logic ack_seen);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wt(H);
            scl = 1'b1; wt(H);
            scl = 1'b0;
        end
        sda_drv = ninth; wt(H);
        scl = 1'b1; wt(H/2);
        ack_seen = sda_oe;
        wt(H/2);
        scl = 1'b0; wt(H);
    endtask

    typedef struct packed {
        logic [6:0] addr;
        logic       rw;
        logic [6:0] own;
        logic       aen;
        logic       hit;
        logic       ack;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{7'h52, 1'b0, 7'h52, 1'b1, 1'b1, 1'b1},
        '{7'h52, 1'b1, 7'h52, 1'b1, 1'b1, 1'b1},
        '{7'h53, 1'b0, 7'h52, 1'b1, 1'b0, 1'b0},
        '{7'h12, 1'b0, 7'h52, 1'b1, 1'b0, 1'b0},
        '{7'h78, 1'b0, 7'h52, 1'b1, 1'b1, 1'b1},
        '{7'h7B, 1'b1, 7'h52, 1'b1, 1'b1, 1'b1},
        '{7'h52, 1'b0, 7'h52, 1'b0, 1'b1, 1'b0},
        '{7'h7C, 1'b0, 7'h52, 1'b1, 1'b0, 1'b0},
        '{7'h7C, 1'b1, 7'h7C, 1'b1, 1'b1, 1'b1}
    };

    initial begin
        logic ack;
        int   base;
        rst = 1'b1; wt(5);
        // R1
        check("R1 sda_oe", sda_oe, 0);
        check("R1 irq", irq, 0);
        check("R1 rx_valid", rx_valid, 0);
        check("R1 dir_flag", dir_flag, 0);
        check("R1 addressed", addressed, 0);
        rst = 1'b0; wt(H);

        // R2 R3 R5 R6 address table
        for (int v = 0; v < NV; v++) begin
            own_addr = VT[v].own;
            ack_en = VT[v].aen;
            do_start();
            base = irq_cnt;
            send_byte({VT[v].addr, VT[v].rw}, 1'b1, ack);
            check($sformatf("R2/R3 irq vec%0d", v), irq_cnt - base, {31'b0, VT[v].hit});
            check($sformatf("R6 ack vec%0d", v), ack, VT[v].ack);
            check($sformatf("R5 addressed vec%0d", v), addressed, VT[v].hit);
            if (VT[v].hit) check($sformatf("R5 dir vec%0d", v), dir_flag, VT[v].rw);
            do_stop();
            check($sformatf("R9 stop vec%0d", v), addressed, 0);
        end

        // R7 write data, ack enabled then disabled
        own_addr = 7'h52; ack_en = 1'b1;
        do_start();
        send_byte({7'h52, 1'b0}, 1'b1, ack);
        base = rxv_cnt;
        send_byte(8'hA5, 1'b1, ack);
        check("R7 rx count", rxv_cnt - base, 1);
        check("R7 rx data", rx_data, 8'hA5);
        check("R6 data ack on", ack, 1);
        ack_en = 1'b0;
        send_byte(8'h3C, 1'b1, ack);
        check("R7 rx data 2", rx_data, 8'h3C);
        check("R6 data ack off", ack, 0);
        do_stop();
        ack_en = 1'b1;

        // R4 mismatch then data is ignored
        do_start();
        base = rxv_cnt;
        send_byte({7'h33, 1'b0}, 1'b1, ack);
        send_byte(8'h5A, 1'b1, ack);
        check("R4 no rx", rxv_cnt - base, 0);
        check("R4 no ack", ack, 0);
        check("R4 rx_data kept", rx_data, 8'h3C);
        do_stop();

        // R8 read: ACK keeps, NACK ends
        do_start();
        send_byte({7'h52, 1'b1}, 1'b1, ack);
        base = oe_cnt;
        send_byte(8'hFF, 1'b0, ack);
        check("R8 ack keeps", addressed, 1);
        check("R8 no drive", oe_cnt - base, 0);
        send_byte(8'hFF, 1'b1, ack);
        check("R8 nack ends", addressed, 0);
        base = rxv_cnt;
        send_byte(8'h00, 1'b1, ack);
        check("R8 ignored after nack", rxv_cnt - base + {31'b0, ack}, 0);
        do_stop();

        // R9 repeated start
        do_start();
        send_byte({7'h52, 1'b0}, 1'b1, ack);
        check("R9 first hit", addressed, 1);
        do_start();
        send_byte({7'h11, 1'b0}, 1'b1, ack);
        check("R9 rstart miss", addressed, 0);
        do_start();
        base = irq_cnt;
        send_byte({7'h52, 1'b1}, 1'b1, ack);
        check("R9 rstart hit irq", irq_cnt - base, 1);
        check("R9 rstart dir", dir_flag, 1);
        check("R9 rstart addressed", addressed, 1);
        do_stop();
        check("R9 stop", addressed, 0);

        check("R10 oe rise while scl high", oe_bad, 0);
        summary();
    end

endmodule